// File: doc/BRIEF.md
# Low-Power Tick Source Controller

This block supplies the slow timebase tick used by a real-time clock and power-manager domain. It runs entirely on a fast reference clock and produces a one-cycle tick enable. It never produces a gated or multiplexed clock. Out of reset there is no usable slow crystal, so the tick comes from a divider that counts fast reference cycles and pulses once every 112 of them. The domain keeps running that way for as long as software leaves the slow oscillator off.

Software writes a small control register to turn the slow oscillator on. The block then brings the raw slow-oscillator waveform into the reference domain through a flop synchronizer and counts its rising edges. After a set number of edges it declares the oscillator stable and raises a ready status bit. The next slow edge becomes the first tick taken from the slow source. From that cycle the divider is held at zero, so no tick is lost or duplicated at the handover.

The same register holds a power-down-enable bit. The sleep power-down request for the fast oscillator asserts only while the sleep input is high, power-down is enabled, the slow oscillator is on, and it has been declared ready. There is no data stream here: all pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset the control bits read as zero, ready is low, `tick_o` is low and `pd_req_o` is low.
- R2: While the divider is the tick source, `tick_o` is a single-cycle pulse that occurs once every DIV (default 112) reference cycles. The first pulse comes in the 112th cycle after reset is released.
- R3: A cycle with `reg_we_i` high loads bit 0 of `reg_wdata_i` as oscillator-on and bit 1 as power-down-enable. `reg_rdata_o` returns oscillator-on in bit 0, power-down-enable in bit 1 and ready in bit 2. Writing bit 2 has no effect.
- R4: A rising edge of `slow_osc_i` is seen through a two-flop synchronizer. An input that is high at clock edge n and was low at clock edge n-1 counts as an edge in the cycle after edge n+1. While oscillator-on is clear, slow edges have no effect on `tick_o` or on ready.
- R5: With oscillator-on set, ready (read bit 2) rises in the cycle after the STAB_EDGES-th synchronized rising edge counted since the enable took effect.
- R6: The first synchronized edge seen while ready is high produces a tick and switches the source to the slow oscillator. From then on, `tick_o` equals the synchronized edge pulse and the divider produces no tick.
- R7: Writing oscillator-on to zero clears ready in the next cycle and returns the tick source to the divider. The divider restarts from zero, so the next fallback tick comes 112 cycles after the write edge.
- R8: `pd_req_o` is high exactly when `sleep_i`, power-down-enable, oscillator-on and ready are all high. Otherwise a power-down-enable setting is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 3 | Write data: bit 0 oscillator-on, bit 1 power-down-enable, bit 2 ignored |
| reg_rdata_o | output | 3 | Read data: bit 0 oscillator-on, bit 1 power-down-enable, bit 2 ready |
| slow_osc_i | input | 1 | Raw slow-oscillator waveform, asynchronous to clk_i |
| sleep_i | input | 1 | Sleep state indication from the power manager |
| tick_o | output | 1 | Single-cycle slow timebase tick enable |
| pd_req_o | output | 1 | Request to power down the fast oscillator during sleep |

## Verification
The assertions assume that the slow waveform holds each level for at least two reference cycles, so the synchronizer never turns two source edges into one. They also assume the divider ratio is larger than one. The stimulus changes the slow input one time unit after a clock edge, with half periods of four cycles or more, and drives register writes and sleep the same way. A behavioural model tracks input history, the enable, the stabilization count and the divider phase, and it is compared with every output on each falling clock edge.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;
  localparam int CTL_ON_BIT  = 0;
  localparam int CTL_PDE_BIT = 1;
  localparam int STS_RDY_BIT = 2;
  localparam int REG_W       = 3;

  typedef enum logic {
    SRC_DIV  = 1'b0,
    SRC_SLOW = 1'b1
  } tick_src_e;

  typedef struct packed {
    logic pde;
    logic on;
  } ctl_t;
endpackage

// File: rtl/lpclk_sync_edge.sv
module lpclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its delayed copy
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/lpclk_divider.sv
module lpclk_divider #(
  parameter int DIV = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_DIV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_DIV_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o); // R6
endmodule

// File: rtl/lpclk_stab.sv
module lpclk_stab #(
  parameter int EDGES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic ok_o
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (edge_i && !ok_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) ok_q <= 1'b1;
    end
  end

  assign ok_o = ok_q;

  AST_OK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ok_o); // R7
  AST_OK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(edge_i)); // R5
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl #(
  parameter int DIV         = 112,
  parameter int STAB_EDGES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_wdata_i,
  output logic [2:0] reg_rdata_o,
  input  logic       slow_osc_i,
  input  logic       sleep_i,
  output logic       tick_o,
  output logic       pd_req_o
);
  import lpclk_pkg::*;

  ctl_t      ctl_q;
  tick_src_e src_q;
  logic      slow_edge, div_tick, stab_ok;
  logic      ready, slow_act, handover, off_write, div_clr;

  // control register; bit 2 of the write data is not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (reg_we_i) ctl_q <= '{pde: reg_wdata_i[CTL_PDE_BIT], on: reg_wdata_i[CTL_ON_BIT]};
  end

  lpclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (slow_osc_i),
    .rise_o  (slow_edge)
  );

  lpclk_stab #(.EDGES(STAB_EDGES)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_q.on),
    .edge_i (slow_edge),
    .ok_o   (stab_ok)
  );

  // ready is masked by the enable so that clearing it takes effect at once
  assign ready     = stab_ok & ctl_q.on;
  assign slow_act  = (src_q == SRC_SLOW) & ctl_q.on;
  assign handover  = ready & slow_edge & (src_q == SRC_DIV);
  assign off_write = reg_we_i & ~reg_wdata_i[CTL_ON_BIT] & ctl_q.on;
  assign div_clr   = slow_act | handover | off_write;

  lpclk_divider #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .tick_o (div_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    src_q <= SRC_DIV;
    else if (!ctl_q.on)             src_q <= SRC_DIV;
    else if (handover)              src_q <= SRC_SLOW;
  end

  always_comb begin
    if (slow_act)      tick_o = slow_edge;
    else if (handover) tick_o = 1'b1;
    else               tick_o = div_tick;
  end

  assign pd_req_o = sleep_i & ctl_q.pde & ready;

  always_comb begin
    reg_rdata_o              = '0;
    reg_rdata_o[CTL_ON_BIT]  = ctl_q.on;
    reg_rdata_o[CTL_PDE_BIT] = ctl_q.pde;
    reg_rdata_o[STS_RDY_BIT] = ready;
  end

  AST_PD_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_o |-> (stab_ok && ctl_q.on)); // R8
  AST_SLOW_NO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_act |-> !div_tick); // R6
  AST_SLOW_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_act |-> stab_ok); // R6
endmodule

// File: tb/test_lpclk_ctrl.sv
module test_lpclk_ctrl;
  localparam int DIV  = 112;
  localparam int STAB = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] wd = 3'b000;
  logic       slow = 1'b0;
  logic       sleep = 1'b0;
  logic [2:0] rdata;
  logic       tick, pd;

  always #10 clk = ~clk;

  lpclk_ctrl #(.DIV(DIV), .STAB_EDGES(STAB), .SYNC_STAGES(2)) i_lpclk_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_wdata_i (wd),
    .reg_rdata_o (rdata), .slow_osc_i (slow), .sleep_i (sleep),
    .tick_o (tick), .pd_req_o (pd)
  );

  int compared = 0, mismatched = 0, cyc = 0, slow_half = 4;

  // behavioural model state
  bit h0, h1, h2, m_on, m_pd, m_ok, m_slow;
  int m_e, m_cnt;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // model outputs from current state
  function automatic bit f_edge(); return h1 && !h2; endfunction
  function automatic bit f_rdy();  return m_ok && m_on; endfunction
  function automatic bit f_ho();   return f_rdy() && f_edge() && !m_slow; endfunction
  function automatic bit f_tick();
    if (m_slow && m_on) return f_edge();
    return f_ho() || (m_cnt == DIV - 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check(tick == f_tick(), "R2 R4 R6 tick", tick, f_tick());
      check(rdata == {f_rdy(), m_pd, m_on}, "R3 R5 R7 status", rdata, {f_rdy(), m_pd, m_on});
      check(pd == (sleep && m_pd && f_rdy()), "R8 pd_req", pd, sleep && m_pd && f_rdy());
    end
  end

  always @(posedge clk) begin
    bit e, ho, sa, offw, nslow;
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_on = 0; m_pd = 0; m_ok = 0; m_slow = 0; m_e = 0; m_cnt = 0;
    end else begin
      e = f_edge(); ho = f_ho(); sa = m_slow && m_on;
      offw = we && !wd[0] && m_on;
      nslow = m_on && (m_slow || ho);
      if (sa || ho || offw) m_cnt = 0;
      else m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      if (!m_on) begin m_e = 0; m_ok = 0; end
      else if (e && !m_ok) begin
        if (m_e == STAB - 1) m_ok = 1;
        m_e++;
      end
      m_slow = nslow;
      if (we) begin m_on = wd[0]; m_pd = wd[1]; end
      h2 = h1; h1 = h0; h0 = slow;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    forever begin
      repeat (slow_half) @(posedge clk);
      #1 slow = ~slow;
    end
  end

  task automatic wr(input logic [2:0] v);
    @(posedge clk); #1 we = 1'b1; wd = v;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic until_tick(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 1000);
  endtask

  initial begin
    int k;
    sleep = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 3'b000 && tick == 1'b0 && pd == 1'b0, "R1 reset state", {rdata, tick, pd}, 0);
    until_tick(k);
    check(k == DIV - 1, "R2 first fallback tick", k, DIV - 1);
    until_tick(k);
    check(k == DIV, "R2 fallback period", k, DIV);
    check(rdata[2] == 1'b0, "R4 no ready while off", rdata[2], 0);
    wr(3'b110);
    @(negedge clk);
    check(rdata == 3'b010, "R3 bit2 ignored", rdata, 3'b010);
    check(pd == 1'b0, "R8 pde alone ignored", pd, 0);
    wr(3'b011);
    repeat (STAB * 2 * 4 + 8) @(posedge clk);
    @(negedge clk);
    check(rdata[2] == 1'b1, "R5 ready after stabilization", rdata[2], 1);
    repeat (200) @(posedge clk);
    #1 sleep = 1'b0;
    repeat (50) @(posedge clk);
    #1 sleep = 1'b1;
    repeat (50) @(posedge clk);
    wr(3'b010);
    check(rdata == 3'b010, "R7 ready cleared", rdata, 3'b010);
    until_tick(k);
    check(k == DIV, "R7 divider restart", k, DIV);
    slow_half = 19;
    wr(3'b011);
    repeat (800) @(posedge clk);
    wr(3'b001);
    repeat (30) @(posedge clk);
    wr(3'b000);
    wr(3'b011);
    repeat (700) @(posedge clk);
    wr(3'b000);
    repeat (300) @(posedge clk);
    summary();
  end
endmodule